// File: doc/BRIEF.md
# Protected Software Interrupt Register Bank

This block is one register slice of a 32-source interrupt controller. It holds a software-interrupt pending vector, a strobe location that clears pending bits, and a one-bit protection switch. The pending vector is ORed with the hardware interrupt lines, and the result leaves the block as the raw request vector, ahead of any masking. Software raises an interrupt by writing ones to the set location. It retires the interrupt by writing ones to the clear location. Zero bits in either write leave the matching pending bits as they were.

The bus side works as a request stream and a response stream. A request is taken in any cycle where `req_valid` is high. `req_ready` is always high, so the block never applies back-pressure. Every accepted request, read or write, produces exactly one response one cycle later, with `rsp_valid` high. The response path cannot be stalled, so the consumer must take it in that cycle.

A privilege flag travels with each request. When the protection switch is on, a request without the flag is rejected at the set and clear locations. The protection switch itself always rejects unflagged requests. A rejected request changes no state and returns zero data with `rsp_err` high.

Top module: `sirq_regbank`

## Requirements
- R1: After reset the pending vector is 0 and protection is off. `raw_req` then equals `hw_irq`, and `rsp_valid` is low.
- R2: An accepted write to offset 0x18 sets each pending bit whose write-data bit is 1 and leaves every other bit unchanged. An accepted read of 0x18 returns the pending vector.
- R3: An accepted write to offset 0x1C clears each pending bit whose write-data bit is 1 and leaves the others unchanged. A read of 0x1C returns 0 with no error.
- R4: `raw_req` is the bitwise OR of `hw_irq` and the pending vector. It follows `hw_irq` in the same cycle and follows a pending-bit change from the cycle after the write.
- R5: Bit 0 of offset 0x20 is the protection switch, where 1 means on. Bits 31:1 read as 0 and ignore writes.
- R6: A request to offset 0x20 with `req_priv` low is rejected whatever the protection state.
- R7: With protection on, a request to 0x18 or 0x1C with `req_priv` low is rejected. A rejected request leaves all state unchanged and returns `rsp_rdata` = 0 with `rsp_err` = 1.
- R8: With protection off, requests to 0x18 and 0x1C are accepted whatever `req_priv` is.
- R9: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high and is low at all other times. `req_ready` is always high.
- R10: A request to any other offset changes no state and returns 0 with `rsp_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | Request carries privilege |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_rdata | output | 32 | Read data (0 for writes and rejects) |
| rsp_err | output | 1 | Request was rejected |
| hw_irq | input | 32 | Hardware interrupt lines |
| raw_req | output | 32 | Hardware lines ORed with pending bits |

## Verification
The pending vector reaches `raw_req` directly, so a pending bit set or cleared in error shows on that output in the very next cycle. It also shows in the next read of 0x18. A protection bit in the wrong state stays hidden until an unprivileged request meets it. That request then gets an error where none was due, or it gets through and changes state. The bench therefore sends many unprivileged requests with the switch both on and off, and it checks every response and `raw_req` after each transfer.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int unsigned OFS_SET  = 32'h18;
  localparam int unsigned OFS_CLR  = 32'h1C;
  localparam int unsigned OFS_PROT = 32'h20;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_SET  = 2'd1,
    K_CLR  = 2'd2,
    K_PROT = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic      valid;
    logic      write;
    reg_kind_e kind;
    logic      reject;
  } acc_t;

endpackage

// File: rtl/sirq_access_gate.sv
module sirq_access_gate
  import sirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic              priv,
  input  logic              prot_en,
  output acc_t              acc
);

  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_PROT = ADDR_W'(OFS_PROT);

  reg_kind_e kind;

  always_comb begin
    unique case (addr)
      A_SET:   kind = K_SET;
      A_CLR:   kind = K_CLR;
      A_PROT:  kind = K_PROT;
      default: kind = K_NONE;
    endcase
  end

  // The switch register needs privilege always; the pending pair only when the switch is on.
  logic need_priv;
  always_comb begin
    case (kind)
      K_PROT:       need_priv = 1'b1;
      K_SET, K_CLR: need_priv = prot_en;
      default:      need_priv = 1'b0;
    endcase
  end

  always_comb begin
    acc.valid  = valid;
    acc.write  = write;
    acc.kind   = kind;
    acc.reject = valid && need_priv && !priv;
  end

  p_user_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !prot_en && (kind == K_SET || kind == K_CLR)) |-> !acc.reject);

  p_priv_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && priv) |-> !acc.reject);

endmodule

// File: rtl/sirq_soft_reg.sv
module sirq_soft_reg #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_we,
  input  logic               clr_we,
  input  logic [NUM_SRC-1:0] wmask,
  input  logic [NUM_SRC-1:0] hw_irq,
  output logic [NUM_SRC-1:0] soft_q,
  output logic [NUM_SRC-1:0] raw_req
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                     soft_q[i] <= 1'b0;
      else if (clr_we && wmask[i])    soft_q[i] <= 1'b0;  // clear has priority
      else if (set_we && wmask[i])    soft_q[i] <= 1'b1;
    end
    assign raw_req[i] = hw_irq[i] | soft_q[i];
  end

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((soft_q & $past(wmask)) == $past(wmask)));

  p_set_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((soft_q & ~$past(wmask)) == ($past(soft_q) & ~$past(wmask))));

  p_clr_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((soft_q & $past(wmask)) == '0));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(soft_q));

endmodule

// File: rtl/sirq_prot_reg.sv
module sirq_prot_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic wbit,
  output logic prot_en
);

  always_ff @(posedge clk) begin
    if (!rst_n)  prot_en <= 1'b0;
    else if (we) prot_en <= wbit;
  end

  p_prot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(prot_en));

endmodule

// File: rtl/sirq_resp.sv
module sirq_resp
  import sirq_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  acc_t               acc,
  input  logic [NUM_SRC-1:0] soft_q,
  input  logic               prot_en,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err
);

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (!acc.write && !acc.reject) begin
      case (acc.kind)
        K_SET:   rd_mux = DATA_W'(soft_q);
        K_PROT:  rd_mux = DATA_W'(prot_en);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= acc.valid;
      rsp_rdata <= acc.valid ? rd_mux : '0;
      rsp_err   <= acc.valid && acc.reject;
    end
  end

  p_rsp_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc.valid |=> rsp_valid);

  p_rsp_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc.valid |=> !rsp_valid);

  p_rej_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));

  p_prot_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc.kind == K_PROT) |-> (rsp_rdata[DATA_W-1:1] == '0));

endmodule

// File: rtl/sirq_regbank.sv
module sirq_regbank
  import sirq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               req_priv,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  input  logic [NUM_SRC-1:0] hw_irq,
  output logic [NUM_SRC-1:0] raw_req
);

  acc_t               acc;
  logic               prot_en;
  logic [NUM_SRC-1:0] soft_q;
  logic               wr_ok;
  logic               set_we, clr_we, prot_we;

  assign req_ready = 1'b1;

  sirq_access_gate #(.ADDR_W(ADDR_W)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (req_valid),
    .write   (req_write),
    .addr    (req_addr),
    .priv    (req_priv),
    .prot_en (prot_en),
    .acc     (acc)
  );

  assign wr_ok   = acc.valid && acc.write && !acc.reject;
  assign set_we  = wr_ok && (acc.kind == K_SET);
  assign clr_we  = wr_ok && (acc.kind == K_CLR);
  assign prot_we = wr_ok && (acc.kind == K_PROT);

  sirq_soft_reg #(.NUM_SRC(NUM_SRC)) u_soft (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_we  (set_we),
    .clr_we  (clr_we),
    .wmask   (req_wdata[NUM_SRC-1:0]),
    .hw_irq  (hw_irq),
    .soft_q  (soft_q),
    .raw_req (raw_req)
  );

  sirq_prot_reg u_prot (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (prot_we),
    .wbit    (req_wdata[0]),
    .prot_en (prot_en)
  );

  sirq_resp #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .soft_q    (soft_q),
    .prot_en   (prot_en),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  p_rej_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc.reject) |=> ($stable(soft_q) && $stable(prot_en)));

  p_unmapped_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc.kind == K_NONE) |=> ($stable(soft_q) && $stable(prot_en) && !rsp_err));

  p_prot_user_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv && req_addr == ADDR_W'(OFS_PROT)) |=> (rsp_err && $stable(prot_en)));

endmodule

// File: tb/sirq_regbank_tb.sv
module sirq_regbank_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_SET  = 12'h018;
  localparam logic [11:0] A_CLR  = 12'h01C;
  localparam logic [11:0] A_PROT = 12'h020;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_priv;
  logic        req_ready;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [31:0] hw_irq, raw_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] soft_m = '0;
  logic        prot_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sirq_regbank u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .hw_irq(hw_irq), .raw_req(raw_req)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit model_reject(input logic [11:0] a, input bit priv);
    if (a == A_PROT) return !priv;
    if (a == A_SET || a == A_CLR) return prot_m && !priv;
    return 1'b0;
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    if (a == A_SET)  return soft_m;
    if (a == A_PROT) return {31'd0, prot_m};
    return '0;
  endfunction

  // One transfer: driven at a falling edge, response sampled at the next falling edge.
  task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d, input bit priv,
                      input logic [31:0] hw, input string tag);
    bit          rej;
    logic [31:0] exp_rd;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_priv = priv;
    hw_irq = hw;
    rej    = model_reject(a, priv);
    exp_rd = (rej || wr) ? 32'd0 : model_read(a);
    if (wr && !rej) begin
      if (a == A_SET)  soft_m = soft_m | d;
      if (a == A_CLR)  soft_m = soft_m & ~d;
      if (a == A_PROT) prot_m = d[0];
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, {tag, " R9 rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
    check(rsp_err == rej, {tag, " R7 rsp_err"}, {31'd0, rsp_err}, {31'd0, rej});
    check(rsp_rdata == exp_rd, {tag, " R2 rsp_rdata"}, rsp_rdata, exp_rd);
    check(raw_req == (hw_irq | soft_m), {tag, " R4 raw_req"}, raw_req, hw_irq | soft_m);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] seed_v;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_priv = 1'b0; hw_irq = 32'h0000_00F0;
    seed_v = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid == 1'b0, "R1 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
    check(raw_req == hw_irq, "R1 raw_req equals hw_irq", raw_req, hw_irq);
    check(req_ready == 1'b1, "R9 req_ready", {31'd0, req_ready}, 32'd1);
    xfer(1'b0, A_SET,  '0, 1'b1, 32'h0, "R1 pending read");
    xfer(1'b0, A_PROT, '0, 1'b1, 32'h0, "R1 prot read");
    // R2 set and read
    xfer(1'b1, A_SET, 32'hA5A5_0001, 1'b1, 32'h0, "R2 set");
    xfer(1'b1, A_SET, 32'h0000_0000, 1'b1, 32'h0, "R2 zero write keeps");
    xfer(1'b0, A_SET, '0, 1'b0, 32'h0100_0000, "R2 readback");
    // R3 clear and clear-offset read
    xfer(1'b1, A_CLR, 32'h0000_0101, 1'b0, 32'h0, "R3 clear");
    xfer(1'b0, A_CLR, '0, 1'b1, 32'h0, "R3 clr read zero");
    xfer(1'b0, A_SET, '0, 1'b1, 32'h0, "R3 readback");
    // R6 switch needs privilege even when off
    xfer(1'b1, A_PROT, 32'h1, 1'b0, 32'h0, "R6 user prot write");
    xfer(1'b0, A_PROT, '0, 1'b0, 32'h0, "R6 user prot read");
    // R5 upper bits ignored
    xfer(1'b1, A_PROT, 32'hFFFF_FFFF, 1'b1, 32'h0, "R5 prot on");
    xfer(1'b0, A_PROT, '0, 1'b1, 32'h0, "R5 prot read");
    // R7 protection on blocks user
    xfer(1'b1, A_SET, 32'hFFFF_FFFF, 1'b0, 32'h0, "R7 user set blocked");
    xfer(1'b1, A_CLR, 32'hFFFF_FFFF, 1'b0, 32'h0, "R7 user clr blocked");
    xfer(1'b0, A_SET, '0, 1'b0, 32'h0, "R7 user read blocked");
    xfer(1'b0, A_SET, '0, 1'b1, 32'h0, "R7 priv read");
    // R8 protection off lets user through
    xfer(1'b1, A_PROT, 32'h0, 1'b1, 32'h0, "R8 prot off");
    xfer(1'b1, A_SET, 32'h0000_8000, 1'b0, 32'h0, "R8 user set");
    xfer(1'b0, A_SET, '0, 1'b0, 32'h0, "R8 user read");
    // R10 unmapped
    xfer(1'b1, 12'h024, 32'hFFFF_FFFF, 1'b1, 32'h0, "R10 unmapped write");
    xfer(1'b0, 12'h000, '0, 1'b0, 32'h0, "R10 unmapped read");
    // R9 idle after transfer
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 no response when idle", {31'd0, rsp_valid}, 32'd0);
    // R4 hw lines follow same cycle
    hw_irq = 32'h1234_5678; #1;
    check(raw_req == (hw_irq | soft_m), "R4 hw same cycle", raw_req, hw_irq | soft_m);

    for (int k = 0; k < 600; k++) begin
      logic [11:0] a;
      int unsigned pick;
      pick = $urandom_range(0, 9);
      a = (pick < 4) ? A_SET : (pick < 7) ? A_CLR : (pick < 9) ? A_PROT : 12'h02C;
      xfer(1'($urandom_range(0, 1)), a, $urandom, 1'($urandom_range(0, 1)), $urandom, "random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule